// File: doc/BRIEF.md
# Power Domain Up/Down Sequencer

This block steps a single switchable power island through its power-up and power-down sequences. It drives a 16-bit control word to the island: two power-switch stage enables, an isolation clamp, an active-low domain reset, a clock gate and four SRAM sleep lines. Between steps it waits on the switch status returns, on the SRAM sleep acknowledgements and on a bus-protection handshake. Each wait is bounded by a timeout, and an expired wait freezes the outputs and raises an error.

Requests are pulses on `req_valid`, with `req_on` giving the direction. Requests are honoured only after a valid unlock word has been written on the key port. The block reports busy, done, reject, timeout error, and the settled or transitional state of the island as seen on the two switch status returns.

Top module: `pd_sequencer`

## Requirements
- R1: After reset `ctrl_word` is 0x0F12, `bprot_req` equals `BPROT_EN`, and `busy`, `done`, `reject` and `timeout_err` are low. The `ctrl_word` layout is: bit 0 domain reset (active low), bit 1 isolation, bit 2 first switch stage, bit 3 second switch stage, bit 4 clock gate, bits 11:8 SRAM sleep; all other bits are 0.
- R2: A request is ignored unless the most recent key write had bits 31:16 equal to 0x0B16 and bit 0 set. A key write that does not match locks the block again.
- R3: Power-up changes one output per clock cycle, in this order: set bit 2, set bit 3, wait for both status returns high, clear bit 4, clear bit 1, set bit 0, clear bits 11:8, wait for the masked SRAM acks to be low, drop `bprot_req`, wait for `bprot_ack` low.
- R4: Power-down changes one output per clock cycle, in this order: raise `bprot_req`, wait for `bprot_ack` high, set bits 11:8, wait for all masked SRAM acks high, set bit 1, clear bit 0, set bit 4, clear bit 2, clear bit 3, wait for both status returns low.
- R5: `dom_on` is high only when both status returns are high. `dom_mixed` is high only when exactly one of them is high.
- R6: The SRAM waits look only at the ack bits selected by `ACK_MASK`. With an empty mask, each SRAM wait ends after one cycle.
- R7: A wait that lasts `TIMEOUT*PRESCALE` cycles aborts the sequence. `timeout_err` rises, `busy` falls and the outputs hold. The next accepted request clears the error and runs its full sequence.
- R8: With `BPROT_EN` at 0, `bprot_req` stays low and both protection steps are skipped.
- R9: A request that arrives while `busy` is high gives a one-cycle `reject` pulse, and the running sequence carries on unchanged.
- R10: A request for the state already reached gives `done` in the next cycle and changes no output.
- R11: `done` pulses for one cycle in the cycle after the last step of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_we | input | 1 | Key word write strobe |
| key_data | input | 32 | Key word |
| req_valid | input | 1 | Request pulse |
| req_on | input | 1 | Request direction, 1 = power up |
| sw_ack_a | input | 1 | First switch stage status |
| sw_ack_b | input | 1 | Second switch stage status |
| sram_ack | input | 4 | SRAM sleep acknowledgements |
| bprot_ack | input | 1 | Bus protection engaged |
| ctrl_word | output | 16 | Island control word |
| bprot_req | output | 1 | Bus protection request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| reject | output | 1 | Request refused while busy |
| timeout_err | output | 1 | Wait timed out |
| dom_on | output | 1 | Both status returns high |
| dom_mixed | output | 1 | Exactly one status return high |

## Verification
Two instances run side by side. One uses bus protection, a full mask and no prescaling. The other has protection off, a two-bit mask with the unmasked acks held high, and a prescale of two. In the second instance, a design that read unmasked acks would hang until it timed out, and one that ignored the skip would stall on a protection ack that never comes. An ack responder that freezes on command drives both instances into timeout. This catches an off-by-one in the prescaled count, outputs that move after the abort, and a retry that fails to clear the error. Back-to-back requests catch a design that lets a request in while busy, and repeated same-direction requests catch one that re-runs a finished sequence. A bad key with bit 0 clear, and a relock after unlocking, catch a gate that checks only half of the key.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int SRAM_W = 4;
  localparam int CTRL_W = 16;
  localparam logic [15:0] UNLOCK_KEY = 16'h0B16;
  localparam int B_RSTB = 0;
  localparam int B_ISO  = 1;
  localparam int B_PON  = 2;
  localparam int B_PON2 = 3;
  localparam int B_CLKD = 4;
  localparam int B_SRAM = 8;

  typedef enum logic [4:0] {
    S_OFF, S_ON, S_FAULT,
    U_PA, U_PB, U_WSW, U_CLK, U_ISO, U_RST, U_SRAM, U_WSR, U_BP, U_WBP,
    D_BP, D_WBP, D_SRAM, D_WSR, D_ISO, D_RST, D_CLK, D_PA, D_PB, D_WSW
  } seq_state_e;
endpackage

// File: rtl/pd_key_gate.sv
module pd_key_gate
  import pd_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  output logic        unlocked
);
  logic unl_q, unl_d;
  logic unused_bits;

  assign unused_bits = ^key_data[15:1];

  always_comb begin
    unl_d = (key_data[31:16] == UNLOCK_KEY) && key_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unl_q <= 1'b0;
    else if (key_we) unl_q <= unl_d;
  end

  assign unlocked = unl_q;
endmodule

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
  parameter int LIMIT    = 100,
  parameter int PRESCALE = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre_q, pre_d;
      assign tick = (pre_q == PW'(PRESCALE - 1));
      always_comb begin
        if (!run)      pre_d = '0;
        else if (tick) pre_d = '0;
        else           pre_d = pre_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && tick && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter bit               BPROT_EN = 1'b1,
  parameter logic [SRAM_W-1:0] ACK_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlocked,
  input  logic              req_valid,
  input  logic              req_on,
  input  logic              sw_ack_a,
  input  logic              sw_ack_b,
  input  logic [SRAM_W-1:0] sram_ack,
  input  logic              bprot_ack,
  input  logic              expired,
  output logic              wait_run,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              bprot_req,
  output logic              busy,
  output logic              done,
  output logic              reject,
  output logic              fault
);
  seq_state_e st_q, st_d;
  logic pa_q, pa_d, pb_q, pb_d, iso_q, iso_d, rstb_q, rstb_d, clkd_q, clkd_d;
  logic bp_q, bp_d, done_q, done_d, rej_q, rej_d;
  logic [SRAM_W-1:0] sram_q, sram_d;
  logic wait_ok;
  logic idle;

  assign idle = (st_q == S_OFF) || (st_q == S_ON) || (st_q == S_FAULT);

  always_comb begin
    st_d = st_q;  pa_d = pa_q;  pb_d = pb_q;  iso_d = iso_q;
    rstb_d = rstb_q;  clkd_d = clkd_q;  sram_d = sram_q;  bp_d = bp_q;
    done_d = 1'b0;
    rej_d  = !idle && req_valid;
    wait_run = 1'b0;
    wait_ok  = 1'b0;
    case (st_q)
      S_OFF, S_ON, S_FAULT: begin
        if (req_valid && unlocked) begin
          if ((st_q != S_FAULT) && (req_on == (st_q == S_ON))) done_d = 1'b1;
          else if (req_on)  st_d = U_PA;
          else if (BPROT_EN) st_d = D_BP;
          else               st_d = D_SRAM;
        end
      end
      U_PA:   begin pa_d = 1'b1;   st_d = U_PB;  end
      U_PB:   begin pb_d = 1'b1;   st_d = U_WSW; end
      U_WSW:  begin
        wait_run = 1'b1;
        wait_ok  = sw_ack_a && sw_ack_b;
        if (wait_ok) st_d = U_CLK;
      end
      U_CLK:  begin clkd_d = 1'b0; st_d = U_ISO;  end
      U_ISO:  begin iso_d = 1'b0;  st_d = U_RST;  end
      U_RST:  begin rstb_d = 1'b1; st_d = U_SRAM; end
      U_SRAM: begin sram_d = '0;   st_d = U_WSR;  end
      U_WSR:  begin
        wait_run = 1'b1;
        wait_ok  = ((sram_ack & ACK_MASK) == '0);
        if (wait_ok) begin
          st_d   = BPROT_EN ? U_BP : S_ON;
          done_d = !BPROT_EN;
        end
      end
      U_BP:   begin bp_d = 1'b0; st_d = U_WBP; end
      U_WBP:  begin
        wait_run = 1'b1;
        wait_ok  = !bprot_ack;
        if (wait_ok) begin st_d = S_ON; done_d = 1'b1; end
      end
      D_BP:   begin bp_d = 1'b1; st_d = D_WBP; end
      D_WBP:  begin
        wait_run = 1'b1;
        wait_ok  = bprot_ack;
        if (wait_ok) st_d = D_SRAM;
      end
      D_SRAM: begin sram_d = '1; st_d = D_WSR; end
      D_WSR:  begin
        wait_run = 1'b1;
        wait_ok  = ((sram_ack & ACK_MASK) == ACK_MASK);
        if (wait_ok) st_d = D_ISO;
      end
      D_ISO:  begin iso_d = 1'b1;  st_d = D_RST; end
      D_RST:  begin rstb_d = 1'b0; st_d = D_CLK; end
      D_CLK:  begin clkd_d = 1'b1; st_d = D_PA;  end
      D_PA:   begin pa_d = 1'b0;   st_d = D_PB;  end
      D_PB:   begin pb_d = 1'b0;   st_d = D_WSW; end
      D_WSW:  begin
        wait_run = 1'b1;
        wait_ok  = !sw_ack_a && !sw_ack_b;
        if (wait_ok) begin st_d = S_OFF; done_d = 1'b1; end
      end
      default: st_d = S_FAULT;
    endcase
    if (wait_run && !wait_ok && expired) st_d = S_FAULT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_OFF;
      pa_q   <= 1'b0;
      pb_q   <= 1'b0;
      iso_q  <= 1'b1;
      rstb_q <= 1'b0;
      clkd_q <= 1'b1;
      sram_q <= '1;
      bp_q   <= BPROT_EN;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pa_q   <= pa_d;
      pb_q   <= pb_d;
      iso_q  <= iso_d;
      rstb_q <= rstb_d;
      clkd_q <= clkd_d;
      sram_q <= sram_d;
      bp_q   <= bp_d;
      done_q <= done_d;
      rej_q  <= rej_d;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_RSTB] = rstb_q;
    ctrl_word[B_ISO]  = iso_q;
    ctrl_word[B_PON]  = pa_q;
    ctrl_word[B_PON2] = pb_q;
    ctrl_word[B_CLKD] = clkd_q;
    ctrl_word[B_SRAM +: SRAM_W] = sram_q;
  end

  assign bprot_req = bp_q;
  assign busy      = !idle;
  assign done      = done_q;
  assign reject    = rej_q;
  assign fault     = (st_q == S_FAULT);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
  import pd_seq_pkg::*;
#(
  parameter bit                BPROT_EN = 1'b1,
  parameter logic [SRAM_W-1:0] ACK_MASK = 4'hF,
  parameter int                TIMEOUT  = 100,
  parameter int                PRESCALE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        req_valid,
  input  logic        req_on,
  input  logic        sw_ack_a,
  input  logic        sw_ack_b,
  input  logic [3:0]  sram_ack,
  input  logic        bprot_ack,
  output logic [15:0] ctrl_word,
  output logic        bprot_req,
  output logic        busy,
  output logic        done,
  output logic        reject,
  output logic        timeout_err,
  output logic        dom_on,
  output logic        dom_mixed
);
  logic unlocked, wait_run, expired;

  pd_key_gate u_key (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data), .unlocked(unlocked)
  );

  pd_wait_timer #(.LIMIT(TIMEOUT), .PRESCALE(PRESCALE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .expired(expired)
  );

  pd_seq_fsm #(.BPROT_EN(BPROT_EN), .ACK_MASK(ACK_MASK)) u_fsm (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked),
    .req_valid(req_valid), .req_on(req_on),
    .sw_ack_a(sw_ack_a), .sw_ack_b(sw_ack_b),
    .sram_ack(sram_ack), .bprot_ack(bprot_ack),
    .expired(expired), .wait_run(wait_run),
    .ctrl_word(ctrl_word), .bprot_req(bprot_req),
    .busy(busy), .done(done), .reject(reject), .fault(timeout_err)
  );

  assign dom_on    = sw_ack_a && sw_ack_b;
  assign dom_mixed = sw_ack_a ^ sw_ack_b;
endmodule

// File: rtl/pd_sequencer_chk.sv
module pd_sequencer_chk #(
  parameter bit BPROT_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        reject,
  input logic        done,
  input logic        timeout_err,
  input logic        dom_on,
  input logic        dom_mixed,
  input logic        bprot_req,
  input logic [15:0] ctrl_word
);
  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ctrl_word[4:0] ^ $past(ctrl_word[4:0]),
                |(ctrl_word[11:8] ^ $past(ctrl_word[11:8]))}) <= 1);

  assert_clk_after_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_word[4]) |-> (ctrl_word[2] && ctrl_word[3]));

  assert_rst_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[0]) |-> (!ctrl_word[1] && !ctrl_word[4]));

  assert_iso_after_sram_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_word[1]) |-> (ctrl_word[11:8] == 4'hF));

  assert_switch_off_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_word[2]) |-> (ctrl_word[1] && !ctrl_word[0] && ctrl_word[4]));

  assert_status_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dom_on && dom_mixed));

  assert_fault_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> !busy);

  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> reject);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  generate
    if (BPROT_EN) begin : g_bp
      assert_bp_release_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bprot_req) |-> (ctrl_word[11:8] == 4'h0 && ctrl_word[0]));
    end else begin : g_nobp
      assert_bp_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bprot_req);
    end
  endgenerate
endmodule

bind pd_sequencer pd_sequencer_chk #(.BPROT_EN(BPROT_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .reject(reject),
  .done(done), .timeout_err(timeout_err), .dom_on(dom_on), .dom_mixed(dom_mixed),
  .bprot_req(bprot_req), .ctrl_word(ctrl_word)
);

// File: tb/pd_sequencer_tb.sv
`timescale 1ns/1ps

module pd_env #(
  parameter logic [3:0] FORCE_HI = 4'h0
) (
  input  logic        clk,
  input  logic        stuck,
  input  logic [15:0] ctrl,
  input  logic        bp_req,
  output logic        sw_a,
  output logic        sw_b,
  output logic [3:0]  sram_ack,
  output logic        bp_ack
);
  logic a1, b1, bp1;
  logic [3:0] s1;
  initial begin
    a1 = 0; b1 = 0; bp1 = 0; s1 = 0;
    sw_a = 0; sw_b = 0; sram_ack = FORCE_HI; bp_ack = 0;
  end
  always @(negedge clk) begin
    if (!stuck) begin
      a1 <= ctrl[2];  sw_a <= a1;
      b1 <= ctrl[3];  sw_b <= b1;
      s1 <= ctrl[11:8]; sram_ack <= s1 | FORCE_HI;
      bp1 <= bp_req;  bp_ack <= bp1;
    end
  end
endmodule

module pd_ref_model #(
  parameter bit         BP    = 1'b1,
  parameter logic [3:0] MASK  = 4'hF,
  parameter int         LIMIT = 100,
  parameter int         PRE   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        req_valid,
  input  logic        req_on,
  input  logic        sw_a,
  input  logic        sw_b,
  input  logic [3:0]  sram_ack,
  input  logic        bp_ack,
  output logic [15:0] ctrl_e,
  output logic        bp_e,
  output logic        busy_e,
  output logic        done_e,
  output logic        rej_e,
  output logic        err_e
);
  localparam int PA1 = 1, PB1 = 2, WSWH = 3, CLK0 = 4, ISO0 = 5, RST1 = 6, SR0 = 7, WSRL = 8,
                 BP0 = 9, WBPL = 10, BP1 = 11, WBPH = 12, SR1 = 13, WSRH = 14, ISO1 = 15,
                 RST0 = 16, CLK1 = 17, PA0 = 18, PB0 = 19, WSWL = 20;
  int plan[$];
  int cnt;
  bit unl, is_on, going;
  logic pa, pb, iso, rstb, clkd;
  logic [3:0] sram;

  task automatic adv();
    void'(plan.pop_front());
    cnt = 0;
    if (plan.size() == 0) begin done_e = 1; is_on = going; end
  endtask

  task automatic wt(input bit ok);
    if (ok) adv();
    else if (cnt == LIMIT * PRE - 1) begin err_e = 1; plan.delete(); cnt = 0; end
    else cnt++;
  endtask

  task automatic load(input bit on);
    going = on;
    cnt = 0;
    if (on) begin
      plan = '{PA1, PB1, WSWH, CLK0, ISO0, RST1, SR0, WSRL};
      if (BP) begin plan.push_back(BP0); plan.push_back(WBPL); end
    end else begin
      plan.delete();
      if (BP) begin plan.push_back(BP1); plan.push_back(WBPH); end
      plan.push_back(SR1); plan.push_back(WSRH); plan.push_back(ISO1); plan.push_back(RST0);
      plan.push_back(CLK1); plan.push_back(PA0); plan.push_back(PB0); plan.push_back(WSWL);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plan.delete(); cnt = 0; unl = 0; is_on = 0; going = 0;
      pa = 0; pb = 0; iso = 1; rstb = 0; clkd = 1; sram = 4'hF; bp_e = BP;
      busy_e = 0; done_e = 0; rej_e = 0; err_e = 0;
    end else begin
      done_e = 0; rej_e = 0;
      if (plan.size() != 0) begin
        if (req_valid) rej_e = 1;
        case (plan[0])
          PA1:  begin pa = 1;   adv(); end
          PB1:  begin pb = 1;   adv(); end
          WSWH: wt(sw_a && sw_b);
          CLK0: begin clkd = 0; adv(); end
          ISO0: begin iso = 0;  adv(); end
          RST1: begin rstb = 1; adv(); end
          SR0:  begin sram = 0; adv(); end
          WSRL: wt((sram_ack & MASK) == 0);
          BP0:  begin bp_e = 0; adv(); end
          WBPL: wt(!bp_ack);
          BP1:  begin bp_e = 1; adv(); end
          WBPH: wt(bp_ack);
          SR1:  begin sram = 4'hF; adv(); end
          WSRH: wt((sram_ack & MASK) == MASK);
          ISO1: begin iso = 1;  adv(); end
          RST0: begin rstb = 0; adv(); end
          CLK1: begin clkd = 1; adv(); end
          PA0:  begin pa = 0;   adv(); end
          PB0:  begin pb = 0;   adv(); end
          default: wt(!sw_a && !sw_b);
        endcase
      end else if (req_valid && unl) begin
        if (!err_e && (req_on == is_on)) done_e = 1;
        else begin err_e = 0; load(req_on); end
      end
      if (key_we) unl = (key_data[31:16] == 16'h0B16) && key_data[0];
      busy_e = (plan.size() != 0);
    end
    ctrl_e = {4'h0, sram, 3'b000, clkd, pb, pa, iso, rstb};
  end
endmodule

module pd_sequencer_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic key_we = 0, req_valid = 0, req_on = 0, stuck = 0;
  logic [31:0] key_data = 0;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  logic [15:0] d0_ctrl, d1_ctrl, m0_ctrl, m1_ctrl;
  logic d0_bp, d0_busy, d0_done, d0_rej, d0_err, d0_on, d0_mix;
  logic d1_bp, d1_busy, d1_done, d1_rej, d1_err, d1_on, d1_mix;
  logic m0_bp, m0_busy, m0_done, m0_rej, m0_err;
  logic m1_bp, m1_busy, m1_done, m1_rej, m1_err;
  logic e0_a, e0_b, e0_bpa, e1_a, e1_b, e1_bpa;
  logic [3:0] e0_s, e1_s;

  pd_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
    .req_valid(req_valid), .req_on(req_on), .sw_ack_a(e0_a), .sw_ack_b(e0_b),
    .sram_ack(e0_s), .bprot_ack(e0_bpa), .ctrl_word(d0_ctrl), .bprot_req(d0_bp),
    .busy(d0_busy), .done(d0_done), .reject(d0_rej), .timeout_err(d0_err),
    .dom_on(d0_on), .dom_mixed(d0_mix));
  pd_env #(.FORCE_HI(4'h0)) u_env0 (.clk(clk), .stuck(stuck), .ctrl(d0_ctrl), .bp_req(d0_bp),
    .sw_a(e0_a), .sw_b(e0_b), .sram_ack(e0_s), .bp_ack(e0_bpa));
  pd_ref_model #(.BP(1'b1), .MASK(4'hF), .LIMIT(100), .PRE(1)) u_m0 (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data), .req_valid(req_valid),
    .req_on(req_on), .sw_a(e0_a), .sw_b(e0_b), .sram_ack(e0_s), .bp_ack(e0_bpa),
    .ctrl_e(m0_ctrl), .bp_e(m0_bp), .busy_e(m0_busy), .done_e(m0_done), .rej_e(m0_rej), .err_e(m0_err));

  pd_sequencer #(.BPROT_EN(1'b0), .ACK_MASK(4'h3), .TIMEOUT(100), .PRESCALE(2)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
    .req_valid(req_valid), .req_on(req_on), .sw_ack_a(e1_a), .sw_ack_b(e1_b),
    .sram_ack(e1_s), .bprot_ack(e1_bpa), .ctrl_word(d1_ctrl), .bprot_req(d1_bp),
    .busy(d1_busy), .done(d1_done), .reject(d1_rej), .timeout_err(d1_err),
    .dom_on(d1_on), .dom_mixed(d1_mix));
  pd_env #(.FORCE_HI(4'hC)) u_env1 (.clk(clk), .stuck(stuck), .ctrl(d1_ctrl), .bp_req(d1_bp),
    .sw_a(e1_a), .sw_b(e1_b), .sram_ack(e1_s), .bp_ack(e1_bpa));
  pd_ref_model #(.BP(1'b0), .MASK(4'h3), .LIMIT(100), .PRE(2)) u_m1 (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data), .req_valid(req_valid),
    .req_on(req_on), .sw_a(e1_a), .sw_b(e1_b), .sram_ack(e1_s), .bp_ack(e1_bpa),
    .ctrl_e(m1_ctrl), .bp_e(m1_bp), .busy_e(m1_busy), .done_e(m1_done), .rej_e(m1_rej), .err_e(m1_err));

  task automatic chk(input string what, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference models
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && !finished) begin
        chk("d0 ctrl", "R3 R4", d0_ctrl, m0_ctrl);
        chk("d0 bprot", "R4", d0_bp, m0_bp);
        chk("d0 busy", "R9", d0_busy, m0_busy);
        chk("d0 done", "R11", d0_done, m0_done);
        chk("d0 reject", "R9", d0_rej, m0_rej);
        chk("d0 err", "R7", d0_err, m0_err);
        chk("d0 on", "R5", d0_on, e0_a & e0_b);
        chk("d0 mixed", "R5", d0_mix, e0_a ^ e0_b);
        chk("d1 ctrl", "R6", d1_ctrl, m1_ctrl);
        chk("d1 bprot", "R8", d1_bp, m1_bp);
        chk("d1 busy", "R9", d1_busy, m1_busy);
        chk("d1 done", "R11", d1_done, m1_done);
        chk("d1 reject", "R9", d1_rej, m1_rej);
        chk("d1 err", "R7", d1_err, m1_err);
      end
    end
  end

  task automatic pulse_req(input logic on);
    @(negedge clk); req_valid = 1; req_on = on;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic write_key(input logic [31:0] w);
    @(negedge clk); key_we = 1; key_data = w;
    @(negedge clk); key_we = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (!d0_busy && !d1_busy) break;
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk); #1;
    // R1 reset state
    chk("reset ctrl", "R1", d0_ctrl, 32'h0F12);
    chk("reset bprot", "R1", d0_bp, 1);
    chk("reset alt bprot", "R1", d1_bp, 0);
    chk("reset flags", "R1", {d0_busy, d0_done, d0_rej, d0_err}, 0);

    // R2 locked: request ignored
    pulse_req(1);
    repeat (20) @(negedge clk); #1;
    chk("locked ctrl", "R2", d0_ctrl, 32'h0F12);
    write_key(32'h0B16_0000);
    pulse_req(1);
    repeat (20) @(negedge clk); #1;
    chk("bad key ctrl", "R2", d0_ctrl, 32'h0F12);

    // R3 power up
    write_key(32'h0B16_0001);
    pulse_req(1);
    wait_idle();
    chk("up ctrl", "R3", d0_ctrl, 32'h000D);
    chk("up bprot", "R3", d0_bp, 0);
    chk("up status", "R5", {d0_on, d0_mix}, 2'b10);
    chk("alt up ctrl", "R6", d1_ctrl, 32'h000D);
    chk("alt bprot", "R8", d1_bp, 0);

    // R10 same-state request
    pulse_req(1); #1;
    chk("same-state done", "R10", {d0_done, d0_busy}, 2'b10);
    chk("same-state ctrl", "R10", d0_ctrl, 32'h000D);

    // R9 request while busy
    pulse_req(0);
    pulse_req(1); #1;
    chk("busy reject", "R9", d0_rej, 1);
    wait_idle();
    chk("down ctrl", "R4", d0_ctrl, 32'h0F12);
    chk("down bprot", "R4", d0_bp, 1);
    chk("alt down ctrl", "R6", d1_ctrl, 32'h0F12);
    chk("down status", "R5", {d0_on, d0_mix}, 2'b00);

    // R7 timeout and recovery
    stuck = 1;
    pulse_req(1);
    wait_idle();
    chk("timeout err", "R7", {d0_err, d0_busy}, 2'b10);
    chk("timeout frozen", "R7", d0_ctrl, 32'h0F1E);
    chk("alt timeout err", "R7", d1_err, 1);
    stuck = 0;
    repeat (4) @(negedge clk);
    pulse_req(1);
    wait_idle();
    chk("recover ctrl", "R7", d0_ctrl, 32'h000D);
    chk("recover err", "R7", {d0_err, d1_err}, 2'b00);

    // R2 relock
    write_key(32'h1234_0001);
    pulse_req(0);
    repeat (30) @(negedge clk); #1;
    chk("relock ctrl", "R2", d0_ctrl, 32'h000D);
    chk("relock busy", "R2", d0_busy, 0);

    finish_run();
  end
endmodule